// File: doc/BRIEF.md
# Twelve-pin GPIO controller with per-pin interrupt triggers

This block is a general-purpose I/O controller. Software reaches it through a 32-bit register port made of a word address, a write strobe, write data and read data. Register writes take effect on the clock edge where the strobe is high. Read data is combinational from the address.

Each pin has an output data bit and a direction bit that drives its output enable. Each pin also has a synchronized input level, which software can read back. A trigger detector on each pin watches the synchronized level in one of five modes: falling edge, rising edge, low level, high level or both edges. When an enabled pin triggers, its status bit latches, and software clears it by writing a 1 to it. A separate mask, with its own set and clear addresses, decides which latched bits reach the single combined interrupt output. A software reset register returns every other register to its reset value.

The address port carries a word index, which is the byte offset divided by four. The pin count is a parameter. The fixed layout of the two mode registers holds at most 16 pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, except the mask register, which reads 0xFFF (all 12 pins masked). `irq`, `pin_oe` and `pin_out` are zero.
- R2: The direction register sits at word index 8. A bit of 1 there sets that pin's `pin_oe` bit, which makes the pin an output. The output register sits at index 6 and drives `pin_out`. Both registers read back only bits 11:0: writing 0xFFFFFFFF reads back 0xFFF.
- R3: The input register at index 7 reads the level of each `pin_in` bit after a two-flop synchronizer. A change on a pin is visible two clock edges after it is applied. Writes to index 7 have no effect.
- R4: The mask register is set at index 4 and cleared at index 5. Writing a 1 to a bit at index 4 masks that pin, and writing a 1 to a bit at index 5 unmasks it. Zero bits change nothing at either address. Both indices read back the mask.
- R5: The status register at index 1 latches a 1 for a pin whose detector fires while that pin's bit in the enable register (index 0) is 1. This happens whether or not the pin is masked. A pin that fires while its enable bit is 0 sets nothing. A status bit stays at 1 until it is cleared.
- R6: Writing a 1 to a bit at index 3 clears that status bit. If the pin fires in the same cycle as the clear, the status bit stays at 1. Index 3 reads zero.
- R7: Index 2 reads status AND NOT mask. `irq` is 1 exactly when that value is nonzero.
- R8: Each pin has a 3-bit mode code: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges, 5 to 7 never fire. Pin n below 8 takes its code from bits [4n+2:4n] of index 9. Pin n from 8 up takes its code from bits [4(n-8)+2:4(n-8)] of index 10. The fields read back in place, and the bits outside them read zero.
- R9: Index 15 bit 0 is the software reset, and it reads back. While it is 1, every other register is held at its R1 value and writes to other registers are ignored. Writing 0 releases it.
- R10: Indices 11, 12 and 13 read zero and ignore writes. Writes to the status (1) and masked-status (2) indices have no effect.
- R11: Index 14 is a 12-bit read/write selection register. It resets to zero, reads back bits 11:0 and affects no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pin_in | input | N | Pin levels from the pads, asynchronous |
| pin_out | output | N | Output data to the pads |
| pin_oe | output | N | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default of 12 pins. At that size the second mode register is in use, and so is the split between pin 7 and pin 8. Pin 11, the highest pin, sits in a field at the top of the second register and checks that the field positions come out right. The 0xFFF read-back of the direction, selection and mask registers checks that bits above the pin count are dropped.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int FIELD_W = 4;
  localparam int CODE_W = 3;
  localparam int PINS_PER_MODE_REG = 8;

  typedef enum logic [CODE_W-1:0] {
    TRG_FALL = 3'd0,
    TRG_RISE = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_HIGH = 3'd3,
    TRG_BOTH = 3'd4
  } trg_mode_e;

  localparam logic [ADDR_W-1:0] A_IEN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MSTAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSET  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCLR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_OUT   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IN    = 4'd7;
  localparam logic [ADDR_W-1:0] A_DIR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_MODE0 = 4'd9;
  localparam logic [ADDR_W-1:0] A_MODE1 = 4'd10;
  localparam logic [ADDR_W-1:0] A_USE   = 4'd14;
  localparam logic [ADDR_W-1:0] A_SRST  = 4'd15;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic [CODE_W-1:0] mode,
  output logic              hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    case (mode)
      TRG_FALL: hit = prev_q & ~lvl;
      TRG_RISE: hit = ~prev_q & lvl;
      TRG_LOW:  hit = ~lvl;
      TRG_HIGH: hit = lvl;
      TRG_BOTH: hit = prev_q ^ lvl;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N-1:0]        pin_lvl,
  input  logic [N-1:0]        hit,
  output logic [DATA_W-1:0]   rdata,
  output logic [N-1:0]        ien_q,
  output logic [N-1:0]        status_q,
  output logic [N-1:0]        mask_q,
  output logic [N-1:0]        out_q,
  output logic [N-1:0]        dir_q,
  output logic [CODE_W*N-1:0] mode_q,
  output logic                srst_q
);
  logic [N-1:0] use_q;
  logic [N-1:0] wbits;
  logic [N-1:0] clr_bits;
  logic         unused_wdata;

  assign wbits        = wdata[N-1:0];
  assign clr_bits     = (we && addr == A_CLR) ? wbits : '0;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q   <= 1'b0;
      ien_q    <= '0;
      status_q <= '0;
      mask_q   <= '1;
      out_q    <= '0;
      dir_q    <= '0;
      use_q    <= '0;
      mode_q   <= '0;
    end else begin
      if (we && addr == A_SRST) srst_q <= wdata[0];
      if (srst_q) begin
        ien_q    <= '0;
        status_q <= '0;
        mask_q   <= '1;
        out_q    <= '0;
        dir_q    <= '0;
        use_q    <= '0;
        mode_q   <= '0;
      end else begin
        status_q <= (status_q & ~clr_bits) | (hit & ien_q);
        if (we) begin
          case (addr)
            A_IEN:   ien_q  <= wbits;
            A_MSET:  mask_q <= mask_q | wbits;
            A_MCLR:  mask_q <= mask_q & ~wbits;
            A_OUT:   out_q  <= wbits;
            A_DIR:   dir_q  <= wbits;
            A_USE:   use_q  <= wbits;
            default: ;
          endcase
        end
        for (int i = 0; i < N; i++) begin
          if (we && addr == ((i < PINS_PER_MODE_REG) ? A_MODE0 : A_MODE1))
            mode_q[CODE_W*i +: CODE_W] <=
              wdata[FIELD_W*(i % PINS_PER_MODE_REG) +: CODE_W];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_IEN:   rdata[N-1:0] = ien_q;
      A_STAT:  rdata[N-1:0] = status_q;
      A_MSTAT: rdata[N-1:0] = status_q & ~mask_q;
      A_MSET:  rdata[N-1:0] = mask_q;
      A_MCLR:  rdata[N-1:0] = mask_q;
      A_OUT:   rdata[N-1:0] = out_q;
      A_IN:    rdata[N-1:0] = pin_lvl;
      A_DIR:   rdata[N-1:0] = dir_q;
      A_USE:   rdata[N-1:0] = use_q;
      A_SRST:  rdata[0]     = srst_q;
      default: ;
    endcase
    for (int i = 0; i < N; i++) begin
      if (addr == ((i < PINS_PER_MODE_REG) ? A_MODE0 : A_MODE1))
        rdata[FIELD_W*(i % PINS_PER_MODE_REG) +: CODE_W] =
          mode_q[CODE_W*i +: CODE_W];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0]        lvl;
  logic [N-1:0]        hit;
  logic [N-1:0]        ien_q;
  logic [N-1:0]        status_q;
  logic [N-1:0]        mask_q;
  logic [N-1:0]        out_q;
  logic [N-1:0]        dir_q;
  logic [CODE_W*N-1:0] mode_q;
  logic                srst_q;

  gpio_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpio_trig u_trig (
      .clk(clk), .rst_n(rst_n), .lvl(lvl[g]),
      .mode(mode_q[CODE_W*g +: CODE_W]), .hit(hit[g])
    );
  end

  gpio_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pin_lvl(lvl), .hit(hit), .rdata(reg_rdata),
    .ien_q(ien_q), .status_q(status_q), .mask_q(mask_q), .out_q(out_q),
    .dir_q(dir_q), .mode_q(mode_q), .srst_q(srst_q)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [N-1:0]      pin_oe,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      ien,
  input logic              srst
);
  logic [N-1:0] clrv;
  assign clrv = (we && addr == A_CLR) ? wdata[N-1:0] : '0;

  AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MSTAT) |-> ((rdata != 0) == irq)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat & $past(stat & ~clrv)) == $past(stat & ~clrv)) || $past(srst))); // R5
  AST_NEED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(ien)) == '0)); // R5
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DIR && !srst) |=> (pin_oe == $past(wdata[N-1:0]))); // R2
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MSET && !srst) |=> ((mask & $past(wdata[N-1:0])) == $past(wdata[N-1:0]))); // R4
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mask == '1 && ien == '0 && pin_oe == '0 && !irq)); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
  .rdata(reg_rdata), .irq(irq), .pin_oe(pin_oe), .stat(status_q),
  .mask(mask_q), .ien(ien_q), .srst(srst_q)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rc(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rc("R1 ien", 4'd0, 32'h0);
    rc("R1 status", 4'd1, 32'h0);
    rc("R1 mstatus", 4'd2, 32'h0);
    rc("R1 mask", 4'd4, 32'hFFF);
    rc("R1 out", 4'd6, 32'h0);
    rc("R1 dir", 4'd8, 32'h0);
    rc("R1 mode0", 4'd9, 32'h0);
    rc("R1 mode1", 4'd10, 32'h0);
    rc("R1 srst", 4'd15, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pin_oe", {20'b0, pin_oe}, 32'h0);
    chk("R1 pin_out", {20'b0, pin_out}, 32'h0);
  endtask

  task automatic t_dir_out;
    wr(4'd8, 32'hFFFF_FFFF);
    rc("R2 dir readback", 4'd8, 32'hFFF);
    chk("R2 pin_oe all", {20'b0, pin_oe}, 32'hFFF);
    wr(4'd8, 32'h0000_0C03);
    chk("R2 pin_oe partial", {20'b0, pin_oe}, 32'hC03);
    wr(4'd6, 32'hFFFF_FA5A);
    chk("R2 pin_out", {20'b0, pin_out}, 32'hA5A);
    rc("R2 out readback", 4'd6, 32'hA5A);
  endtask

  task automatic t_input;
    @(negedge clk);
    pin_in = 12'h3C5;
    @(negedge clk);
    rc("R3 one edge not yet", 4'd7, 32'h0);
    wait_cyc(1);
    rc("R3 input level", 4'd7, 32'h3C5);
    wr(4'd7, 32'h0);
    rc("R3 input read-only", 4'd7, 32'h3C5);
  endtask

  task automatic t_mask;
    wr(4'd5, 32'h0000_000F);
    rc("R4 mask clear", 4'd4, 32'hFF0);
    wr(4'd4, 32'h0000_0001);
    rc("R4 mask set", 4'd4, 32'hFF1);
    wr(4'd4, 32'h0);
    rc("R4 set zero no effect", 4'd4, 32'hFF1);
    wr(4'd5, 32'h0);
    rc("R4 clear zero no effect", 4'd5, 32'hFF1);
  endtask

  task automatic t_edges;
    @(negedge clk);
    pin_in = '0;
    wait_cyc(4);
    wr(4'd9, 32'h0000_5410);
    wr(4'd10, 32'h0000_0001);
    rc("R8 mode0 readback", 4'd9, 32'h5410);
    wr(4'd0, 32'h0000_010F);
    wr(4'd3, 32'hFFF);
    rc("R5 status clean", 4'd1, 32'h0);
    @(negedge clk);
    pin_in = 12'h10E;
    wait_cyc(3);
    rc("R8 rise/both/none", 4'd1, 32'h106);
    rc("R7 masked status", 4'd2, 32'h006);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr(4'd3, 32'h106);
    rc("R6 clear", 4'd1, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    pin_in = 12'h001;
    wait_cyc(3);
    rc("R8 falling edges", 4'd1, 32'h004);
    @(negedge clk);
    pin_in = 12'h000;
    wait_cyc(3);
    rc("R8 pin0 falling", 4'd1, 32'h005);
    @(negedge clk);
    pin_in = 12'h200;
    wait_cyc(3);
    @(negedge clk);
    pin_in = 12'h000;
    wait_cyc(3);
    rc("R5 disabled pin9 ignored", 4'd1, 32'h005);
    wr(4'd3, 32'hFFF);
  endtask

  task automatic t_level;
    wr(4'd10, 32'h0000_2301);
    rc("R8 mode1 readback", 4'd10, 32'h2301);
    wr(4'd0, 32'h0000_0C00);
    wait_cyc(2);
    wr(4'd3, 32'hFFF);
    rc("R6 trigger beats clear", 4'd1, 32'h800);
    @(negedge clk);
    pin_in = 12'h400;
    wait_cyc(3);
    rc("R8 level high pin10", 4'd1, 32'hC00);
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    wr(4'd5, 32'h0000_0C00);
    chk("R7 unmasked irq", {31'b0, irq}, 32'h1);
    rc("R7 masked status lvl", 4'd2, 32'hC00);
    @(negedge clk);
    pin_in = 12'h800;
    wait_cyc(3);
    wr(4'd3, 32'hFFF);
    rc("R6 clear after level gone", 4'd1, 32'h0);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_reserved;
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF);
    rc("R10 res 11", 4'd11, 32'h0);
    rc("R10 res 12", 4'd12, 32'h0);
    rc("R10 res 13", 4'd13, 32'h0);
    wr(4'd1, 32'hFFF);
    wr(4'd2, 32'hFFF);
    rc("R10 status read-only", 4'd1, 32'h0);
    chk("R10 irq unchanged", {31'b0, irq}, 32'h0);
    rc("R6 clear reads zero", 4'd3, 32'h0);
    wr(4'd14, 32'h0000_0123);
    rc("R11 use readback", 4'd14, 32'h123);
    wr(4'd14, 32'hFFFF_FFFF);
    rc("R11 use width", 4'd14, 32'hFFF);
    chk("R11 pins untouched", {20'b0, pin_oe}, 32'hC03);
  endtask

  task automatic t_soft_reset;
    wr(4'd15, 32'h1);
    wait_cyc(1);
    rc("R9 srst readback", 4'd15, 32'h1);
    rc("R9 mask reset", 4'd4, 32'hFFF);
    rc("R9 ien reset", 4'd0, 32'h0);
    rc("R9 mode1 reset", 4'd10, 32'h0);
    rc("R9 use reset", 4'd14, 32'h0);
    chk("R9 pin_oe reset", {20'b0, pin_oe}, 32'h0);
    chk("R9 pin_out reset", {20'b0, pin_out}, 32'h0);
    wr(4'd8, 32'hFFF);
    rc("R9 write held off", 4'd8, 32'h0);
    wr(4'd15, 32'h0);
    rc("R9 srst released", 4'd15, 32'h0);
    wr(4'd8, 32'h00F);
    rc("R9 writes resume", 4'd8, 32'h00F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_input();
    t_mask();
    t_edges();
    t_level();
    t_reserved();
    t_soft_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule